// File: doc/BRIEF.md
# Software Interrupt Vector Sequencer

This block sits in the decode stage of a small processor core. It recognises a one-word software-interrupt instruction whose low five bits name one of 32 vector slots. When it takes such an instruction, it sends the program counter to the slot's program address and pushes the return address onto a return-address stack it holds internally. It also discards the two words that the fetch unit has already fetched beyond the instruction. No interrupt mask can hold the instruction back.

A per-slot mask input marks which slots belong to external interrupt sources. When the selected slot is one of them, the block acts as the hardware interrupt path would: it pulses an acknowledge tagged with the slot index and asks the core to set its global interrupt mask. The instruction keeps the block busy for a base cost plus a wait-state penalty. No further instruction is taken while it is busy. The rest of the core pops the return stack through a separate request.

Top module: `swi_vector_seq`

## Requirements
- R1: An instruction is accepted at a rising clock edge when `dec_valid` is high, `busy` is low and `insn[15:5]` equals 11'b10111110011. A word with any other upper pattern causes no output activity.
- R2: In the cycle after acceptance, `pc_load` is high for exactly one cycle and `pc_next` equals 2*K, where K = `insn[4:0]` (K=3 gives 0x0006).
- R3: In the same cycle as `pc_load`, `push_en` is high and `push_data` equals `cur_pc`+1 (modulo 2^16), taken at acceptance.
- R4: If `ext_mask[K]` is 1, then in the `pc_load` cycle `ack` and `intm_set` are high for exactly one cycle and `ack_idx` equals K. If `ext_mask[K]` is 0, neither pulse occurs.
- R5: `busy` is high for exactly 4 + 3*`wait_states` consecutive cycles, starting in the cycle after acceptance. `wait_states` is sampled at acceptance.
- R6: An instruction offered while `busy` is high is ignored. It causes no `pc_load`, no push and no acknowledge.
- R7: `flush` is high for exactly two consecutive cycles, starting with the `pc_load` cycle.
- R8: The return stack holds 8 entries. `stk_top` shows the newest entry one cycle after a push, and `stk_level` counts entries and saturates at 8. A push onto a full stack discards the oldest entry without any indication.
- R9: A `pop_req` with no push in the same cycle removes the newest entry when `stk_level` is above 0. A pop on an empty stack is ignored. An empty stack shows `stk_top` = 0.
- R10: After reset, `busy`, `pc_load`, `push_en`, `flush`, `ack`, `intm_set` and `stk_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Instruction word valid at decode |
| insn | input | 16 | Instruction word |
| cur_pc | input | 16 | Address of the instruction word |
| ext_mask | input | 32 | Bit K set: slot K is an external source |
| wait_states | input | 3 | Program-memory wait states (0 to 7) |
| pop_req | input | 1 | Return-stack pop from the core |
| busy | output | 1 | Sequence in progress, new instructions refused |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 16 | Vector slot address |
| push_en | output | 1 | Return address pushed this cycle |
| push_data | output | 16 | Return address |
| flush | output | 1 | Discard a speculatively fetched word |
| ack | output | 1 | Interrupt-acknowledge pulse |
| ack_idx | output | 5 | Slot index that was acknowledged |
| intm_set | output | 1 | Set the global interrupt mask |
| stk_top | output | 16 | Newest return-stack entry |
| stk_level | output | 4 | Return-stack entry count |

## Verification
On every cycle the assertions check several relations. Every `pc_load` is a lone pulse that arrives inside a busy window that it did not start during. It carries an even target and a push of the previous cycle's PC plus one. An acknowledge and a mask set always come together and only with a redirect, and the stack level never exceeds its depth. The exact length of the busy window for each wait-state setting needs the bench's scenarios to show it. So do the slot-by-slot choice between the external and internal cases, and the oldest-entry loss on overflow, which only shows in the order of the pops that follow.

// File: rtl/swi_pkg.sv
package swi_pkg;

   // total busy cycles for a given wait-state setting
   function automatic int unsigned seq_cycles(int unsigned base_cyc,
                                              int unsigned ws_mult,
                                              int unsigned ws);
      return base_cyc + ws_mult * ws;
   endfunction

   // smallest width able to hold v
   function automatic int unsigned width_for(int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
   parameter int unsigned INSN_W = 16,
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned OPC_W  = 11,
   parameter logic [OPC_W-1:0] OPC_VAL = 11'b10111110011
) (
   input  logic [INSN_W-1:0] insn,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   if (INSN_W != OPC_W + IDX_W) begin : g_bad_split
      $error("swi_decode: opcode and index widths must fill the word");
   end

   assign hit = (insn[INSN_W-1:IDX_W] == OPC_VAL);
   assign idx = insn[IDX_W-1:0];

endmodule

// File: rtl/swi_busy_timer.sv
module swi_busy_timer
   import swi_pkg::*;
#(
   parameter int unsigned WS_W     = 3,
   parameter int unsigned BASE_CYC = 4,
   parameter int unsigned WS_MULT  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WS_W-1:0] ws,
   output logic            busy
);

   localparam int unsigned MAX_CYC = seq_cycles(BASE_CYC, WS_MULT, (1 << WS_W) - 1);
   localparam int unsigned CNT_W   = width_for(MAX_CYC);

   if (BASE_CYC < 1) begin : g_bad_base
      $error("swi_busy_timer: BASE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   if (WS_MULT == 0) begin : g_fixed
      assign load_val = CNT_W'(BASE_CYC - 1);
      logic unused_ws;
      assign unused_ws = ^ws;
   end else begin : g_waited
      assign load_val = CNT_W'(BASE_CYC - 1) + CNT_W'(WS_MULT) * CNT_W'(ws);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/swi_ret_stack.sv
module swi_ret_stack
   import swi_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_val,
   input  logic         pop,
   output logic [W-1:0] top,
   output logic [width_for(DEPTH)-1:0] level
);

   localparam int unsigned PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam int unsigned LVL_W = width_for(DEPTH);

   if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("swi_ret_stack: DEPTH must be a power of two, at least 2");
   end

   logic [PTR_W-1:0] wp;
   logic [PTR_W-1:0] rp;
   logic [W-1:0]     ent [DEPTH];
   logic             pop_ok;

   assign pop_ok = pop && !push && (level != '0);
   assign rp     = wp - PTR_W'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         ent[i] <= '0;
         else if (push && wp == PTR_W'(i))   ent[i] <= push_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         level <= '0;
      end else if (push) begin
         wp <= wp + PTR_W'(1);
         if (level != LVL_W'(DEPTH)) level <= level + LVL_W'(1);
      end else if (pop_ok) begin
         wp    <= rp;
         level <= level - LVL_W'(1);
      end
   end

   assign top = (level == '0) ? '0 : ent[rp];

endmodule

// File: rtl/swi_vector_seq.sv
module swi_vector_seq
   import swi_pkg::*;
#(
   parameter int unsigned INSN_W     = 16,
   parameter int unsigned PC_W       = 16,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned OPC_W      = 11,
   parameter logic [OPC_W-1:0] OPC_VAL = 11'b10111110011,
   parameter int unsigned STK_DEPTH  = 8,
   parameter int unsigned WS_W       = 3,
   parameter int unsigned BASE_CYC   = 4,
   parameter int unsigned WS_MULT    = 3,
   parameter int unsigned SPEC_WORDS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dec_valid,
   input  logic [INSN_W-1:0]     insn,
   input  logic [PC_W-1:0]       cur_pc,
   input  logic [(1<<IDX_W)-1:0] ext_mask,
   input  logic [WS_W-1:0]       wait_states,
   input  logic                  pop_req,
   output logic                  busy,
   output logic                  pc_load,
   output logic [PC_W-1:0]       pc_next,
   output logic                  push_en,
   output logic [PC_W-1:0]       push_data,
   output logic                  flush,
   output logic                  ack,
   output logic [IDX_W-1:0]      ack_idx,
   output logic                  intm_set,
   output logic [PC_W-1:0]       stk_top,
   output logic [width_for(STK_DEPTH)-1:0] stk_level
);

   localparam int unsigned FL_W = width_for(SPEC_WORDS);

   if (PC_W <= IDX_W) begin : g_bad_pc
      $error("swi_vector_seq: PC_W must exceed IDX_W");
   end
   if (SPEC_WORDS < 1 || SPEC_WORDS > BASE_CYC) begin : g_bad_spec
      $error("swi_vector_seq: SPEC_WORDS must lie in 1..BASE_CYC");
   end

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             accept;
   logic [FL_W-1:0]  flush_cnt;

   swi_decode #(
      .INSN_W (INSN_W), .IDX_W (IDX_W), .OPC_W (OPC_W), .OPC_VAL (OPC_VAL)
   ) u_dec (
      .insn (insn), .hit (hit), .idx (idx)
   );

   assign accept = dec_valid && hit && !busy;

   swi_busy_timer #(
      .WS_W (WS_W), .BASE_CYC (BASE_CYC), .WS_MULT (WS_MULT)
   ) u_tmr (
      .clk (clk), .rst_n (rst_n), .start (accept), .ws (wait_states), .busy (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_load   <= 1'b0;
         pc_next   <= '0;
         push_data <= '0;
         ack       <= 1'b0;
         ack_idx   <= '0;
         intm_set  <= 1'b0;
         flush_cnt <= '0;
      end else begin
         pc_load  <= accept;
         ack      <= accept && ext_mask[idx];
         intm_set <= accept && ext_mask[idx];
         if (accept) begin
            pc_next   <= PC_W'({idx, 1'b0});
            push_data <= cur_pc + PC_W'(1);
            ack_idx   <= idx;
            flush_cnt <= FL_W'(SPEC_WORDS);
         end else if (flush_cnt != '0) begin
            flush_cnt <= flush_cnt - FL_W'(1);
         end
      end
   end

   assign push_en = pc_load;
   assign flush   = (flush_cnt != '0);

   swi_ret_stack #(
      .DEPTH (STK_DEPTH), .W (PC_W)
   ) u_stk (
      .clk (clk), .rst_n (rst_n), .push (push_en), .push_val (push_data),
      .pop (pop_req), .top (stk_top), .level (stk_level)
   );

endmodule

// File: rtl/swi_vector_seq_chk.sv
module swi_vector_seq_chk #(
   parameter int unsigned PC_W      = 16,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned STK_DEPTH = 8,
   parameter int unsigned LVL_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PC_W-1:0]  cur_pc,
   input logic             busy,
   input logic             pc_load,
   input logic [PC_W-1:0]  pc_next,
   input logic             push_en,
   input logic [PC_W-1:0]  push_data,
   input logic             ack,
   input logic             intm_set,
   input logic             flush,
   input logic [LVL_W-1:0] stk_level
);

   // R2
   redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load);

   // R2
   redirect_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (pc_next[0] == 1'b0));

   // R3
   ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (push_en && push_data == $past(cur_pc) + PC_W'(1)));

   // R4
   ack_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (pc_load && intm_set));

   // R4
   intm_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intm_set |-> ack);

   // R5
   redirect_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> busy);

   // R6
   no_accept_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> !$past(busy));

   // R7
   flush_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> flush);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_level <= LVL_W'(STK_DEPTH));

endmodule

bind swi_vector_seq swi_vector_seq_chk #(
   .PC_W (PC_W), .IDX_W (IDX_W), .STK_DEPTH (STK_DEPTH),
   .LVL_W (swi_pkg::width_for(STK_DEPTH))
) u_chk (
   .clk (clk), .rst_n (rst_n), .cur_pc (cur_pc), .busy (busy),
   .pc_load (pc_load), .pc_next (pc_next), .push_en (push_en),
   .push_data (push_data), .ack (ack), .intm_set (intm_set),
   .flush (flush), .stk_level (stk_level)
);

// File: tb/swi_vector_seq_tb.sv
module swi_vector_seq_tb;

   localparam logic [10:0] OPC = 11'b10111110011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [15:0] insn = '0;
   logic [15:0] cur_pc = '0;
   logic [31:0] ext_mask = '0;
   logic [2:0]  wait_states = '0;
   logic        pop_req = 1'b0;
   logic        busy, pc_load, push_en, flush, ack, intm_set;
   logic [15:0] pc_next, push_data, stk_top;
   logic [4:0]  ack_idx;
   logic [3:0]  stk_level;

   int checks = 0;
   int fails  = 0;
   logic [15:0] mstk [$];

   always #10 clk = ~clk;

   swi_vector_seq u_dut (
      .clk (clk), .rst_n (rst_n), .dec_valid (dec_valid), .insn (insn),
      .cur_pc (cur_pc), .ext_mask (ext_mask), .wait_states (wait_states),
      .pop_req (pop_req), .busy (busy), .pc_load (pc_load), .pc_next (pc_next),
      .push_en (push_en), .push_data (push_data), .flush (flush), .ack (ack),
      .ack_idx (ack_idx), .intm_set (intm_set), .stk_top (stk_top),
      .stk_level (stk_level)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_top();
      return (mstk.size() == 0) ? 16'h0 : mstk[mstk.size()-1];
   endfunction

   function automatic int exp_busy(input int ws);
      return 4 + 3 * ws;
   endfunction

   task automatic model_push(input logic [15:0] v);
      if (mstk.size() == 8) void'(mstk.pop_front());
      mstk.push_back(v);
   endtask

   task automatic check_stack(input string req);
      chk(stk_top == exp_top(), req, "stk_top", stk_top, exp_top());
      chk(stk_level == 4'(mstk.size()), req, "stk_level", stk_level, mstk.size());
   endtask

   // one software interrupt, plus an ignored attempt while busy
   task automatic run_swi(input logic [4:0] k, input logic [15:0] pc,
                          input logic [2:0] ws, input logic [31:0] mask);
      bit ext = mask[k];
      int bcnt;
      bit stray;
      @(negedge clk);
      dec_valid = 1'b1; insn = {OPC, k}; cur_pc = pc;
      wait_states = ws; ext_mask = mask;
      @(negedge clk);
      // cycle after acceptance: offer another word while busy (R6)
      insn = {OPC, ~k}; cur_pc = pc ^ 16'h5a5a; wait_states = ~ws; ext_mask = ~mask;
      chk(pc_load == 1'b1, "R2", "pc_load", pc_load, 1);
      chk(pc_next == {10'h0, k, 1'b0}, "R2", "pc_next", pc_next, {10'h0, k, 1'b0});
      chk(push_en == 1'b1 && push_data == pc + 16'h1, "R3", "push_data", push_data, pc + 16'h1);
      chk(ack == ext && intm_set == ext, "R4", "ack/intm_set", {ack, intm_set}, {ext, ext});
      if (ext) chk(ack_idx == k, "R4", "ack_idx", ack_idx, k);
      chk(flush == 1'b1, "R7", "flush first", flush, 1);
      model_push(pc + 16'h1);
      bcnt = busy ? 1 : 0;
      stray = 1'b0;
      @(negedge clk);
      chk(flush == 1'b1, "R7", "flush second", flush, 1);
      chk(ack == 1'b0 && intm_set == 1'b0, "R4", "pulse width", {ack, intm_set}, 0);
      check_stack("R8");
      while (busy && bcnt < 40) begin
         bcnt++;
         if (pc_load || ack) stray = 1'b1;
         if (bcnt == 3) chk(flush == 1'b0, "R7", "flush third", flush, 0);
         @(negedge clk);
      end
      dec_valid = 1'b0;
      chk(bcnt == exp_busy(ws), "R5", "busy cycles", bcnt, exp_busy(ws));
      chk(!stray, "R6", "redirect while busy", stray, 0);
      @(negedge clk);
      chk(pc_load == 1'b0, "R6", "late redirect", pc_load, 0);
      check_stack("R6");
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      if (mstk.size() > 0) void'(mstk.pop_back());
      check_stack("R9");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({busy, pc_load, push_en, flush, ack, intm_set} == 6'b0, "R10", "outputs", 
          {busy, pc_load, push_en, flush, ack, intm_set}, 0);
      chk(stk_level == 4'd0, "R10", "stk_level", stk_level, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && stk_top == 16'h0, "R10", "after release", {busy, stk_top}, 0);

      // R2 example: slot 3 -> 0x0006, external
      run_swi(5'd3, 16'h1234, 3'd0, 32'h0000_0008);
      // R4 internal slot: no acknowledge
      run_swi(5'd0, 16'hffff, 3'd1, 32'hffff_fffe);
      // R5 longest window
      run_swi(5'd31, 16'h0100, 3'd7, 32'h8000_0000);

      // R1 wrong upper pattern: no activity
      for (int b = 5; b < 16; b++) begin
         @(negedge clk);
         dec_valid = 1'b1; insn = {OPC, 5'd9} ^ (16'h1 << b);
         @(negedge clk);
         dec_valid = 1'b0;
         chk(pc_load == 1'b0 && busy == 1'b0 && push_en == 1'b0, "R1", "bad opcode",
             {pc_load, busy, push_en}, 0);
      end
      // R1 valid low, good word: no activity
      @(negedge clk);
      insn = {OPC, 5'd4};
      @(negedge clk);
      chk(pc_load == 1'b0 && busy == 1'b0, "R1", "no valid", {pc_load, busy}, 0);

      // R9 drain, then pop on empty
      while (mstk.size() > 0) do_pop();
      do_pop();

      // R8 overflow: 10 pushes, oldest two lost
      for (int i = 0; i < 10; i++)
         run_swi(5'(i), 16'(16'h2000 + 16'(i) * 16'h10), 3'd0, 32'h0);
      chk(stk_level == 4'd8, "R8", "saturated level", stk_level, 8);
      for (int i = 0; i < 9; i++) do_pop();

      // R9 pop and push in the same cycle: push wins
      run_swi(5'd7, 16'h3000, 3'd0, 32'h0);
      @(negedge clk);
      dec_valid = 1'b1; insn = {OPC, 5'd8}; cur_pc = 16'h4000; wait_states = 3'd0;
      @(negedge clk);
      dec_valid = 1'b0; pop_req = 1'b1;   // pop lands on the push edge
      @(negedge clk);
      pop_req = 1'b0;
      model_push(16'h4001);
      check_stack("R9");
      repeat (6) @(negedge clk);

      // random mix
      for (int n = 0; n < 60; n++) begin
         run_swi(5'($urandom_range(31)), 16'($urandom), 3'($urandom_range(7)), $urandom);
         if ($urandom_range(3) == 0) do_pop();
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule